// File: doc/BRIEF.md
# H-Bridge Drive State Arbiter with Fault Latch

This block decides, once per clock, which of the four gate enables of one H-bridge are on. The inputs are a sleep request, an output enable, a brake request, a direction-source select, a direction pin, a direction bit from a serial register, and the chopper's requested phase (charge, slow decay or fast decay). They are resolved in a fixed priority order. The block also takes digital overcurrent and over-temperature flags from the analog sensing, and latches a fault from them. A latched fault keeps the bridge off until the sleep input has gone through a complete low, high, low sequence.

After reset, after sleep ends, and after a fault has been cleared, the bridge stays off for a programmable settling wait. This gives the gate-drive supply time to come up. The output stage never goes straight from one conducting pattern to a different one: it puts one all-off cycle between them, so that a high-side and a low-side switch in the same leg never conduct together.

Top module: `bridge_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, all four gate enables are off and the fault indication is clear.
- R2: Resolution order. Sleep (sleep_n low) forces all gates off at the next clock and restarts the settling wait. Disable (enable low) forces all gates off at the next clock but does not restart the settling wait, so raising enable again drives the bridge right away.
- R3: When awake, enabled, settled and not faulted, a high brake input turns on both low-side gates (ls_gate = 2'b11, hs_gate = 2'b00). While brake is high, the direction inputs and the chop request have no effect.
- R4: With dir_src_serial low, phase_pin selects the direction. With dir_src_serial high, phase_bit selects it and phase_pin is ignored. A value of 1 means forward and 0 means reverse.
- R5: Gate positions: hs_gate[0]=U1, hs_gate[1]=U2, ls_gate[0]=L1, ls_gate[1]=L2. Chop codes: 00 charge, 01 slow, 10 fast, 11 slow. Forward: charge drives U1 and L2, slow drives L1 and L2, fast drives U2 and L1. Reverse swaps U1 with U2 and L1 with L2. Gates follow the inputs one clock later.
- R6: When the gate pattern must change from one non-zero value to a different non-zero value, the outputs spend exactly one clock all off before the new pattern appears.
- R7: Overcurrent latches a fault only after the flag is sampled high on OC_QUAL consecutive clocks, with OC_QUAL = 3/4 of CHOP_CYCLES (12 with the bench settings). A shorter run does not trip, and a low sample restarts the count.
- R8: A single high sample of the over-temperature flag while awake latches a fault.
- R9: A latched fault forces all gates off from the next clock. It stays latched until sleep_n has been sampled low, then high, then low. A partial sequence does not clear it.
- R10: After reset release, after sleep release, or once the fault is cleared and sleep is released, the gates stay off until sleep_n has been sampled high on STARTUP_CYCLES clocks. Drive begins on the clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Low requests sleep; also used for the fault-clear sequence |
| enable | input | 1 | Low forces outputs off while keeping state |
| brake | input | 1 | High requests low-side brake |
| dir_src_serial | input | 1 | Selects phase_bit (1) or phase_pin (0) as direction |
| phase_pin | input | 1 | External direction input, 1 forward |
| phase_bit | input | 1 | Serial-register direction bit, 1 forward |
| chop_req | input | 2 | Chopper phase request: 00 charge, 01 slow, 10 fast, 11 slow |
| oc_flag | input | 1 | Digital overcurrent indication |
| ot_flag | input | 1 | Digital over-temperature indication |
| hs_gate | output | 2 | High-side gate enables {U2,U1} |
| ls_gate | output | 2 | Low-side gate enables {L2,L1} |
| fault_latched | output | 1 | High while a fault is latched |

## Verification
On every clock, the assertions check that sleep, disable and a latched fault each force the gates off at the next clock. They also check that no leg ever has both of its switches on, that brake never enables a high-side switch, that a latched fault cannot clear while sleep_n is high, and that two different conducting patterns are never adjacent. The exact length of the settling wait, the overcurrent qualification count, the rule that a partial sleep sequence leaves the fault set, and the mapping from direction source and chop code to gate pattern can only be shown by the bench scenarios. The bench compares these against its cycle model.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic [1:0] {
    CHOP_CHARGE = 2'b00,
    CHOP_SLOW   = 2'b01,
    CHOP_FAST   = 2'b10,
    CHOP_ALT    = 2'b11
  } chop_e;

  typedef enum logic [1:0] {
    FLT_CLEAR  = 2'b00,
    FLT_WLOW   = 2'b01,
    FLT_WHIGH  = 2'b10,
    FLT_WLOW2  = 2'b11
  } flt_e;

  // hs[0]=U1 hs[1]=U2 ls[0]=L1 ls[1]=L2
  typedef struct packed {
    logic [1:0] hs;
    logic [1:0] ls;
  } gates_t;

  localparam gates_t GATES_OFF   = '{hs: 2'b00, ls: 2'b00};
  localparam gates_t GATES_BRAKE = '{hs: 2'b00, ls: 2'b11};

  function automatic gates_t drive_pattern(input logic fwd, input chop_e chop);
    gates_t g;
    case (chop)
      CHOP_CHARGE: g = '{hs: 2'b01, ls: 2'b10};
      CHOP_FAST:   g = '{hs: 2'b10, ls: 2'b01};
      default:     g = '{hs: 2'b00, ls: 2'b11};
    endcase
    if (!fwd) begin
      g.hs = {g.hs[0], g.hs[1]};
      g.ls = {g.ls[0], g.ls[1]};
    end
    return g;
  endfunction

endpackage

// File: rtl/bridge_startup_timer.sv
module bridge_startup_timer #(
  parameter int unsigned WAIT_CYCLES = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic ready
);
  localparam int unsigned CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = hold || (cnt_q != LIMIT);
    cnt_d  = hold ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ready = (cnt_q == LIMIT);
endmodule

// File: rtl/bridge_fault_latch.sv
module bridge_fault_latch
  import bridge_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_n,
  input  logic oc_flag,
  input  logic ot_flag,
  output logic fault
);
  localparam int unsigned QW = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [QW-1:0] QLAST = QW'(QUAL_CYCLES - 1);

  flt_e          state_q, state_d;
  logic [QW-1:0] occ_q, occ_d;
  logic          oc_trip, trip;

  always_comb begin
    oc_trip = oc_flag && (occ_q == QLAST);
    trip    = sleep_n && (ot_flag || oc_trip);

    if (state_q != FLT_CLEAR || !sleep_n || !oc_flag || oc_trip) occ_d = '0;
    else                                                         occ_d = occ_q + QW'(1);

    state_d = state_q;
    case (state_q)
      FLT_CLEAR: if (trip)     state_d = FLT_WLOW;
      FLT_WLOW:  if (!sleep_n) state_d = FLT_WHIGH;
      FLT_WHIGH: if (sleep_n)  state_d = FLT_WLOW2;
      FLT_WLOW2: if (!sleep_n) state_d = FLT_CLEAR;
      default:                 state_d = FLT_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FLT_CLEAR;
      occ_q   <= '0;
    end else begin
      state_q <= state_d;
      occ_q   <= occ_d;
    end
  end

  assign fault = (state_q != FLT_CLEAR);
endmodule

// File: rtl/bridge_pattern_sel.sv
module bridge_pattern_sel
  import bridge_pkg::*;
(
  input  logic       awake,
  input  logic       fault,
  input  logic       ready,
  input  logic       enable,
  input  logic       brake,
  input  logic       dir_src_serial,
  input  logic       phase_pin,
  input  logic       phase_bit,
  input  logic [1:0] chop_req,
  output gates_t     target
);
  logic fwd;

  always_comb begin
    fwd = dir_src_serial ? phase_bit : phase_pin;
    if (!awake || fault || !ready) target = GATES_OFF;
    else if (!enable)              target = GATES_OFF;
    else if (brake)                target = GATES_BRAKE;
    else                           target = drive_pattern(fwd, chop_e'(chop_req));
  end
endmodule

// File: rtl/bridge_deadtime.sv
module bridge_deadtime
  import bridge_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  gates_t target,
  output gates_t gates
);
  gates_t gates_q, gates_d;
  logic   upd_en;

  always_comb begin
    upd_en  = (target != gates_q);
    gates_d = (gates_q == GATES_OFF) ? target : GATES_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gates_q <= GATES_OFF;
    else if (upd_en) gates_q <= gates_d;
  end

  assign gates = gates_q;
endmodule

// File: rtl/bridge_arbiter.sv
module bridge_arbiter
  import bridge_pkg::*;
#(
  parameter int unsigned STARTUP_CYCLES = 200000,
  parameter int unsigned CHOP_CYCLES    = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_n,
  input  logic       enable,
  input  logic       brake,
  input  logic       dir_src_serial,
  input  logic       phase_pin,
  input  logic       phase_bit,
  input  logic [1:0] chop_req,
  input  logic       oc_flag,
  input  logic       ot_flag,
  output logic [1:0] hs_gate,
  output logic [1:0] ls_gate,
  output logic       fault_latched
);
  localparam int unsigned OC_QUAL = (CHOP_CYCLES * 3) / 4;

  logic   fault, ready;
  gates_t target, gates;

  bridge_fault_latch #(.QUAL_CYCLES(OC_QUAL)) u_fault (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .fault(fault)
  );

  bridge_startup_timer #(.WAIT_CYCLES(STARTUP_CYCLES)) u_wait (
    .clk(clk), .rst_n(rst_n), .hold(!sleep_n || fault), .ready(ready)
  );

  bridge_pattern_sel u_sel (
    .awake(sleep_n), .fault(fault), .ready(ready), .enable(enable),
    .brake(brake), .dir_src_serial(dir_src_serial), .phase_pin(phase_pin),
    .phase_bit(phase_bit), .chop_req(chop_req), .target(target)
  );

  bridge_deadtime u_dt (
    .clk(clk), .rst_n(rst_n), .target(target), .gates(gates)
  );

  assign hs_gate       = gates.hs;
  assign ls_gate       = gates.ls;
  assign fault_latched = fault;
endmodule

// File: rtl/bridge_arbiter_chk.sv
module bridge_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sleep_n,
  input logic       enable,
  input logic       brake,
  input logic [1:0] hs_gate,
  input logic [1:0] ls_gate,
  input logic       fault_latched
);
  logic [3:0] g;
  assign g = {hs_gate, ls_gate};

  AST_SLEEP_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (g == 4'b0000)); // R2
  AST_DISABLE_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (g == 4'b0000)); // R2
  AST_FAULT_FORCES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |=> (g == 4'b0000)); // R9
  AST_FAULT_HELD_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && sleep_n) |=> fault_latched); // R9
  AST_NO_LEG_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate & ls_gate) == 2'b00); // R5
  AST_BRAKE_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_n && enable && brake) |=> (hs_gate == 2'b00)); // R3
  AST_DEAD_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (g != 4'b0000) |=> (g == 4'b0000 || g == $past(g))); // R6
endmodule

bind bridge_arbiter bridge_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .enable(enable), .brake(brake),
  .hs_gate(hs_gate), .ls_gate(ls_gate), .fault_latched(fault_latched)
);

// File: tb/bridge_arbiter_bench.sv
`timescale 1ns/1ps
module bridge_arbiter_bench;
  localparam int LIM  = 20;
  localparam int CHOP = 16;
  localparam int QUAL = (CHOP * 3) / 4;

  logic clk = 1'b0;
  logic rst_n, sleep_n, enable, brake, dir_src_serial, phase_pin, phase_bit;
  logic [1:0] chop_req;
  logic oc_flag, ot_flag;
  logic [1:0] hs_gate, ls_gate;
  logic fault_latched;

  always #5 clk = ~clk;

  bridge_arbiter #(.STARTUP_CYCLES(LIM), .CHOP_CYCLES(CHOP)) u_bridge_arbiter (
    .clk(clk), .rst_n(rst_n), .sleep_n(sleep_n), .enable(enable), .brake(brake),
    .dir_src_serial(dir_src_serial), .phase_pin(phase_pin), .phase_bit(phase_bit),
    .chop_req(chop_req), .oc_flag(oc_flag), .ot_flag(ot_flag),
    .hs_gate(hs_gate), .ls_gate(ls_gate), .fault_latched(fault_latched)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;
  string cur_req = "R1";

  // reference model state
  int su, occ, fst;
  logic [3:0] mg; // {hs, ls}

  function automatic logic [3:0] pat(input logic fwd, input logic [1:0] ch);
    logic [3:0] p;
    if (ch == 2'b00)      p = fwd ? 4'b01_10 : 4'b10_01;
    else if (ch == 2'b10) p = fwd ? 4'b10_01 : 4'b01_10;
    else                  p = 4'b00_11;
    return p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      su = 0; occ = 0; fst = 0; mg = 4'b0;
    end else begin
      logic [3:0] t;
      int fst_old;
      fst_old = fst;
      if (!sleep_n || fst != 0 || su != LIM || !enable) t = 4'b0;
      else if (brake) t = 4'b00_11;
      else t = pat(dir_src_serial ? phase_bit : phase_pin, chop_req);
      if (t != mg) mg = (mg == 4'b0) ? t : 4'b0;
      if (fst == 0) begin
        if (!sleep_n) occ = 0;
        else if (ot_flag) begin fst = 1; occ = 0; end
        else if (oc_flag) begin
          if (occ == QUAL - 1) begin fst = 1; occ = 0; end
          else occ++;
        end else occ = 0;
      end else begin
        occ = 0;
        if (fst == 1 && !sleep_n) fst = 2;
        else if (fst == 2 && sleep_n) fst = 3;
        else if (fst == 3 && !sleep_n) fst = 0;
      end
      if (!sleep_n || fst_old != 0) su = 0;
      else if (su < LIM) su++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // compare against model on every clock, away from the active edge
  always @(negedge clk) if (!done) begin
    chk({hs_gate, ls_gate} == mg, cur_req, "gates", {hs_gate, ls_gate}, mg);
    chk(fault_latched == (fst != 0), cur_req, "fault", fault_latched, (fst != 0));
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_g(input string req, input logic [3:0] e);
    chk({hs_gate, ls_gate} == e, req, "directed gates", {hs_gate, ls_gate}, e);
  endtask

  initial begin
    rst_n = 0; sleep_n = 0; enable = 0; brake = 0; dir_src_serial = 0;
    phase_pin = 1; phase_bit = 0; chop_req = 2'b00; oc_flag = 0; ot_flag = 0;
    step(4);
    cur_req = "R1";
    expect_g("R1", 4'b0);
    chk(fault_latched == 0, "R1", "fault at reset", fault_latched, 0);
    rst_n = 1;
    step(3);
    expect_g("R1", 4'b0);

    // R10: settling wait after sleep release
    cur_req = "R10";
    sleep_n = 1; enable = 1;
    step(LIM);
    expect_g("R10", 4'b0);
    step(1);
    expect_g("R10", 4'b01_10);

    // R5: patterns, forward then reverse
    cur_req = "R5";
    chop_req = 2'b01; step(3); expect_g("R5", 4'b00_11);
    chop_req = 2'b10; step(3); expect_g("R5", 4'b10_01);
    chop_req = 2'b11; step(3); expect_g("R5", 4'b00_11);
    phase_pin = 0; chop_req = 2'b00; step(3); expect_g("R5", 4'b10_01);
    chop_req = 2'b10; step(3); expect_g("R5", 4'b01_10);

    // R6: dead cycle between distinct conducting patterns
    cur_req = "R6";
    chop_req = 2'b01; step(1); expect_g("R6", 4'b0);
    step(1); expect_g("R6", 4'b00_11);
    for (int i = 0; i < 6; i++) begin chop_req = i[1:0]; step(2); end

    // R4: direction source select
    cur_req = "R4";
    chop_req = 2'b00; dir_src_serial = 1; phase_bit = 1; phase_pin = 0;
    step(3); expect_g("R4", 4'b01_10);
    phase_pin = 1; step(1); phase_pin = 0; step(2);
    expect_g("R4", 4'b01_10);
    phase_bit = 0; step(3); expect_g("R4", 4'b10_01);
    dir_src_serial = 0; phase_pin = 1; step(3); expect_g("R4", 4'b01_10);

    // R3: brake overrides direction and chop request
    cur_req = "R3";
    brake = 1; step(3); expect_g("R3", 4'b00_11);
    phase_pin = 0; chop_req = 2'b10; step(2); expect_g("R3", 4'b00_11);
    dir_src_serial = 1; phase_bit = 1; step(2); expect_g("R3", 4'b00_11);

    // R2: disable beats brake; no new settling wait on re-enable
    cur_req = "R2";
    enable = 0; step(1); expect_g("R2", 4'b0);
    step(4);
    brake = 0; chop_req = 2'b00; enable = 1; step(1);
    expect_g("R2", 4'b01_10);
    sleep_n = 0; step(1); expect_g("R2", 4'b0);
    sleep_n = 1; step(LIM); expect_g("R2", 4'b0);
    step(2); expect_g("R2", 4'b01_10);

    // R7: overcurrent qualification
    cur_req = "R7";
    oc_flag = 1; step(QUAL - 1); oc_flag = 0; step(1);
    chk(fault_latched == 0, "R7", "short run no trip", fault_latched, 0);
    oc_flag = 1; step(QUAL - 2); oc_flag = 0; step(1); oc_flag = 1; step(QUAL - 1);
    chk(fault_latched == 0, "R7", "restarted count", fault_latched, 0);
    step(1);
    chk(fault_latched == 1, "R7", "qualified trip", fault_latched, 1);
    oc_flag = 0;
    step(1); expect_g("R7", 4'b0);

    // R9: partial sequence keeps fault, full one clears it
    cur_req = "R9";
    step(5);
    sleep_n = 0; step(2); sleep_n = 1; step(3);
    chk(fault_latched == 1, "R9", "partial sequence", fault_latched, 1);
    expect_g("R9", 4'b0);
    sleep_n = 0; step(1);
    chk(fault_latched == 0, "R9", "cleared", fault_latched, 0);
    step(2);
    cur_req = "R10";
    sleep_n = 1; step(LIM); expect_g("R10", 4'b0);
    step(1); expect_g("R10", 4'b01_10);

    // R8: thermal trip on one sample
    cur_req = "R8";
    ot_flag = 1; step(1); ot_flag = 0;
    chk(fault_latched == 1, "R8", "thermal trip", fault_latched, 1);
    step(1); expect_g("R8", 4'b0);
    sleep_n = 0; step(1); sleep_n = 1; step(1); sleep_n = 0; step(1);
    chk(fault_latched == 0, "R8", "thermal cleared", fault_latched, 0);
    sleep_n = 1; chop_req = 2'b10; step(LIM + 4);
    expect_g("R8", 4'b10_01);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule